// File: doc/BRIEF.md
# Interrupt Request Arbitration Core

This block keeps the pending-request and in-service state of an eight-line interrupt controller. Each input line is watched for a low-to-high transition. An edge on an unmasked line becomes a pending request. The processor is told about new work by a one-cycle pulse, and only when nothing of equal or higher rank is already being serviced. The highest-numbered line always wins. Configuration (mask, vector base, cascade map, master/slave role, automatic end-of-interrupt) comes from a command sequencer outside the block and is held steady on the inputs.

When the processor acknowledges, the block retires the winning request and records it as in service. In automatic end-of-interrupt mode it retires the service at once instead. It then presents the vector base ORed with the line number. On a master whose winning line carries a cascaded controller, it raises a flag so that the downstream controller supplies the vector. End-of-interrupt commands clear one in-service bit, either the highest one or a named one. Any request still pending is then offered to the processor again. The request and in-service registers are visible on ports for readback.

Top module: `irq_arb_core`

## Requirements
- R1: A request is taken only on a rising edge of a line; the previous level of every line is stored. A line held high produces no further request, including when it is unmasked while already high.
- R2: A rising edge on a line whose mask bit is 1 is discarded: the request register keeps its value and no pulse results.
- R3: An unmasked rising edge on line L sets req_q[L] one cycle later. In that same cycle int_pulse is 1 only if svc_q holds no set bit at position L or above.
- R4: The highest-numbered set bit has top priority, both for the line chosen on acknowledge and for the bit cleared by a nonspecific end-of-interrupt.
- R5: With auto_eoi at 0, an acknowledge while requests are pending clears the top request bit and sets the matching in-service bit. In-service bits are set by nothing else.
- R6: With auto_eoi at 1, an acknowledge clears the top request bit, leaves svc_q unchanged, and counts as an end-of-interrupt for re-offering (R8).
- R7: One cycle after an acknowledge of line L, vector equals vec_base | L. slave_vec equals is_master & cascade_map[L]. Both hold until the next acknowledge.
- R8: eoi_top clears the highest set bit of svc_q, and eoi_one clears bit eoi_line. After any end-of-interrupt, if a request is pending and no in-service bit sits at or above the top pending line, int_pulse is 1 in the next cycle.
- R9: int_pulse is a single-cycle pulse for each qualifying event; with no new event it returns to 0.
- R10: An acknowledge with no pending request leaves req_q and svc_q unchanged. It returns vec_base | 7 with slave_vec at 0.
- R11: Synchronous active-high reset clears req_q, svc_q, the stored line levels, int_pulse, vector and slave_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Raw interrupt lines |
| irq_mask | input | 8 | 1 discards edges on that line |
| vec_base | input | 8 | Base ORed with the line number to form the vector |
| cascade_map | input | 8 | 1 marks a line that carries a downstream controller |
| is_master | input | 1 | 1 when this controller is the master |
| auto_eoi | input | 1 | 1 retires service at acknowledge time |
| eoi_top | input | 1 | Nonspecific end-of-interrupt strobe |
| eoi_one | input | 1 | Specific end-of-interrupt strobe |
| eoi_line | input | 3 | Line cleared by eoi_one |
| ack | input | 1 | Acknowledge strobe from the processor |
| int_pulse | output | 1 | One-cycle interrupt pulse toward the processor |
| vector | output | 8 | Vector of the last acknowledge |
| slave_vec | output | 1 | Downstream controller must supply the vector |
| req_q | output | 8 | Pending request bits |
| svc_q | output | 8 | In-service bits |

## Verification
On every cycle the assertions check several invariants. A masked edge never adds a request bit. A pulse is never raised without a pending request. In-service bits appear only on an acknowledge. The slave flag needs the master role. A spurious acknowledge yields the fixed vector, and reset clears the state. Some behaviours can only be shown by the bench's scenarios. These are the gating of the pulse by every in-service level, swept over all line and level pairs, and the order of acknowledges and nonspecific end-of-interrupts. They also include re-offering after end-of-interrupt in both service modes and the vector and slave flag for every line.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned LINE_W = $clog2(LINES);
    localparam int unsigned VEC_W  = 8;

    typedef struct packed {
        logic              any;
        logic [LINE_W-1:0] idx;
    } pick_t;

    function automatic logic [LINES-1:0] line_bit(input logic [LINE_W-1:0] idx);
        logic [LINES-1:0] r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int unsigned N = irq_arb_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines_i;
    end

    assign rise_o = lines_i & ~prev_q;
endmodule

// File: rtl/irq_msb_pick.sv
module irq_msb_pick
    import irq_arb_pkg::*;
#(
    parameter int unsigned N = LINES
) (
    input  logic [N-1:0] vec_i,
    output pick_t        pick_o
);
    always_comb begin
        pick_o = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (vec_i[i]) begin
                pick_o.any = 1'b1;
                pick_o.idx = LINE_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arb_core.sv
module irq_arb_core
    import irq_arb_pkg::*;
#(
    parameter int unsigned N    = LINES,
    parameter int unsigned VW   = VEC_W,
    localparam int unsigned LW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_lines,
    input  logic [N-1:0]  irq_mask,
    input  logic [VW-1:0] vec_base,
    input  logic [N-1:0]  cascade_map,
    input  logic          is_master,
    input  logic          auto_eoi,
    input  logic          eoi_top,
    input  logic          eoi_one,
    input  logic [LW-1:0] eoi_line,
    input  logic          ack,
    output logic          int_pulse,
    output logic [VW-1:0] vector,
    output logic          slave_vec,
    output logic [N-1:0]  req_q,
    output logic [N-1:0]  svc_q
);
    logic [N-1:0] rise_w, acc_w, open_w;
    logic [N-1:0] ack_bit, svc_set, eoi_clr, req_n, svc_n;
    pick_t        req_pick, svc_pick, nxt_pick;
    logic         ack_take, eoi_evt, pulse_n;

    irq_edge_detect #(.N(N)) u_edge (
        .clk(clk), .rst(rst), .lines_i(irq_lines), .rise_o(rise_w)
    );

    irq_msb_pick #(.N(N)) u_pick_req (.vec_i(req_q), .pick_o(req_pick));
    irq_msb_pick #(.N(N)) u_pick_svc (.vec_i(svc_q), .pick_o(svc_pick));
    irq_msb_pick #(.N(N)) u_pick_nxt (.vec_i(req_n), .pick_o(nxt_pick));

    assign acc_w    = rise_w & ~irq_mask;
    assign ack_take = ack & req_pick.any;
    assign ack_bit  = ack_take ? line_bit(req_pick.idx) : '0;
    assign svc_set  = auto_eoi ? '0 : ack_bit;
    assign eoi_clr  = ((eoi_top & svc_pick.any) ? line_bit(svc_pick.idx) : '0)
                    | (eoi_one ? line_bit(eoi_line) : '0);
    assign req_n    = (req_q & ~ack_bit) | acc_w;
    assign svc_n    = (svc_q | svc_set) & ~eoi_clr;
    assign eoi_evt  = eoi_top | eoi_one | (ack_take & auto_eoi);

    // open_w[i]: no in-service bit at position i or above
    for (genvar i = 0; i < int'(N); i++) begin : g_open
        assign open_w[i] = ~|svc_n[N-1:i];
    end

    assign pulse_n = (|(acc_w & open_w))
                   | (eoi_evt & nxt_pick.any & open_w[nxt_pick.idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            svc_q     <= '0;
            int_pulse <= 1'b0;
            vector    <= '0;
            slave_vec <= 1'b0;
        end else begin
            req_q     <= req_n;
            svc_q     <= svc_n;
            int_pulse <= pulse_n;
            if (ack) begin
                vector    <= ack_take ? (vec_base | VW'(req_pick.idx))
                                      : (vec_base | VW'(N-1));
                slave_vec <= ack_take & is_master & cascade_map[req_pick.idx];
            end
        end
    end

    // R2
    masked_edge_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rise_w & irq_mask & ~req_q)) |=>
        ((req_q & $past(rise_w & irq_mask & ~req_q)) == '0));

    // R3
    pulse_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        int_pulse |-> (|req_q));

    // R5
    svc_only_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((svc_q & ~$past(svc_q)) == '0));

    // R7
    slave_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !is_master) |=> !slave_vec);

    // R10
    spurious_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && req_q == '0) |=> (vector == ($past(vec_base) | VW'(N-1)) && !slave_vec));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (req_q == '0 && svc_q == '0 && !int_pulse && !slave_vec));
endmodule

// File: tb/tb_irq_arb_core.sv
`timescale 1ns/1ps
module tb_irq_arb_core;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_lines, irq_mask, vec_base, cascade_map;
    logic       is_master, auto_eoi, eoi_top, eoi_one, ack;
    logic [2:0] eoi_line;
    logic       int_pulse, slave_vec;
    logic [7:0] vector, req_q, svc_q;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // bench reference state
    logic [7:0] m_prev, m_req, m_svc, m_vec;
    logic       m_pulse, m_slv;

    always #5 clk = ~clk;

    irq_arb_core dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .irq_mask(irq_mask),
        .vec_base(vec_base), .cascade_map(cascade_map), .is_master(is_master),
        .auto_eoi(auto_eoi), .eoi_top(eoi_top), .eoi_one(eoi_one),
        .eoi_line(eoi_line), .ack(ack), .int_pulse(int_pulse), .vector(vector),
        .slave_vec(slave_vec), .req_q(req_q), .svc_q(svc_q)
    );

    function automatic int top_of(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    // true when no bit of s sits at position l or higher
    function automatic bit clear_from(input logic [7:0] s, input int l);
        return (s >> l) == 8'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(req_q == m_req, tag, "req_q", req_q, m_req);
        chk(svc_q == m_svc, tag, "svc_q", svc_q, m_svc);
        chk(int_pulse == m_pulse, tag, "int_pulse", int_pulse, m_pulse);
        chk(vector == m_vec, tag, "vector", vector, m_vec);
        chk(slave_vec == m_slv, tag, "slave_vec", slave_vec, m_slv);
    endtask

    // apply current inputs for one clock, advance the reference, compare
    task automatic step(input string tag);
        logic [7:0] acc, rn, sn;
        int hi, t, nt;
        bit eoi;
        acc = irq_lines & ~m_prev & ~irq_mask;
        rn = m_req; sn = m_svc; eoi = 0;
        hi = top_of(m_req);
        if (ack) begin
            if (hi >= 0) begin
                rn[hi] = 1'b0;
                if (auto_eoi) eoi = 1; else sn[hi] = 1'b1;
                m_vec = vec_base | 8'(hi);
                m_slv = is_master & cascade_map[hi];
            end else begin
                m_vec = vec_base | 8'd7;
                m_slv = 1'b0;
            end
        end
        if (eoi_top) begin
            t = top_of(m_svc);
            if (t >= 0) sn[t] = 1'b0;
            eoi = 1;
        end
        if (eoi_one) begin
            sn[eoi_line] = 1'b0;
            eoi = 1;
        end
        rn = rn | acc;
        m_pulse = 1'b0;
        for (int l = 0; l < 8; l++)
            if (acc[l] && clear_from(sn, l)) m_pulse = 1'b1;
        nt = top_of(rn);
        if (eoi && nt >= 0 && clear_from(sn, nt)) m_pulse = 1'b1;
        m_prev = irq_lines; m_req = rn; m_svc = sn;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        ack = 0; eoi_top = 0; eoi_one = 0;
    endtask

    task automatic do_reset();
        rst = 1; irq_lines = 0; irq_mask = 0; ack = 0; eoi_top = 0; eoi_one = 0;
        eoi_line = 0; auto_eoi = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 0;
        m_prev = 0; m_req = 0; m_svc = 0; m_vec = 0; m_pulse = 0; m_slv = 0;
    endtask

    initial begin
        vec_base = 8'h20; cascade_map = 8'h04; is_master = 1;
        do_reset();
        compare_all("R11");

        // R1 / R2: masked edge dropped, later unmask of a held line adds nothing
        irq_mask = 8'h08; irq_lines = 8'h08; step("R2");
        chk(req_q == 8'h00 && !int_pulse, "R2", "masked edge", req_q, 0);
        irq_mask = 8'h00; step("R1");
        step("R1");
        chk(req_q == 8'h00, "R1", "held line no request", req_q, 0);
        irq_lines = 8'h00; step("R1");

        // R3 / R9: edge then pulse for one cycle only
        irq_lines = 8'h02; step("R3");
        chk(int_pulse == 1'b1, "R3", "pulse on edge", int_pulse, 1);
        step("R9");
        chk(int_pulse == 1'b0, "R9", "pulse single cycle", int_pulse, 0);
        irq_lines = 8'h00; step("R9");

        // R10: spurious acknowledge after clearing pending request
        do_reset();
        ack = 1; step("R10");
        chk(vector == (vec_base | 8'd7), "R10", "spurious vector", vector, vec_base | 8'd7);

        // R4 / R5 / R8: two requests, ordered acknowledges and EOIs
        irq_lines = 8'h24; step("R3");
        irq_lines = 8'h00; ack = 1; step("R4");
        chk(vector == (vec_base | 8'd5), "R4", "first ack line 5", vector, vec_base | 8'd5);
        ack = 1; step("R5");
        chk(svc_q == 8'h24, "R5", "both in service", svc_q, 8'h24);
        eoi_top = 1; step("R4");
        chk(svc_q == 8'h04, "R4", "nonspecific clears top", svc_q, 8'h04);
        eoi_one = 1; eoi_line = 3'd2; step("R8");
        chk(svc_q == 8'h00, "R8", "specific clears line 2", svc_q, 0);

        // R8: gated request re-offered after EOI
        do_reset();
        irq_lines = 8'h40; step("R3"); irq_lines = 0; ack = 1; step("R5");
        irq_lines = 8'h08; step("R3");
        chk(int_pulse == 1'b0, "R3", "gated by svc 6", int_pulse, 0);
        eoi_top = 1; step("R8");
        chk(int_pulse == 1'b1, "R8", "re-offer after EOI", int_pulse, 1);
        irq_lines = 0; step("R9");

        // R6: auto EOI leaves svc empty and re-offers the remaining request
        do_reset();
        auto_eoi = 1;
        irq_lines = 8'h12; step("R3"); irq_lines = 0; step("R6");
        ack = 1; step("R6");
        chk(svc_q == 8'h00 && int_pulse, "R6", "auto EOI re-offer", {svc_q, 7'd0, int_pulse}, 1);
        chk(req_q == 8'h02, "R6", "line 4 retired", req_q, 8'h02);
        auto_eoi = 0;

        // R3 sweep: every line against every in-service level (-1 = none)
        for (int s = -1; s < 8; s++) begin
            for (int l = 0; l < 8; l++) begin
                do_reset();
                if (s >= 0) begin
                    irq_lines = 8'(1 << s); step("R3");
                    irq_lines = 0; ack = 1; step("R5");
                end
                irq_lines = 8'(1 << l); step("R3");
                chk(int_pulse == (l > s), "R3", "gate sweep pulse", int_pulse, (l > s));
                chk(req_q[l] == 1'b1, "R3", "gate sweep req", req_q, 8'(1 << l));
                irq_lines = 0;
            end
        end

        // R7 sweep: vector and slave flag for every line, both roles
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 8; l++) begin
                do_reset();
                is_master = m[0]; vec_base = 8'hF0 - 8'(l * 8); cascade_map = 8'hA5;
                irq_lines = 8'(1 << l); step("R7");
                irq_lines = 0; ack = 1; step("R7");
                chk(vector == (vec_base | 8'(l)), "R7", "vector", vector, vec_base | 8'(l));
                chk(slave_vec == (m[0] & cascade_map[l]), "R7", "slave flag",
                    slave_vec, m[0] & cascade_map[l]);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule